// File: doc/BRIEF.md
# Integer Issue Selector with Multiplier Result-Bus Reservation

This block picks, every clock cycle, which waiting micro-ops leave a small reservation pool for three integer lanes. Each lane offers an ALU slot and an address-generation (AGU) slot. Entries are granted oldest first, and a ready entry may pass older entries that are not yet ready. Multiplies run only on lane 0, which feeds a pipelined multiplier of `MUL_LAT` cycles.

A multiply writes its result `MUL_LAT` cycles after it issues. An ordinary ALU micro-op writes back in the cycle it issues. To keep the two from colliding on a result bus, the selector keeps a shift register of pending multiply writebacks. On each reserved cycle it keeps non-multiply ALU micro-ops out of lanes 0 and 1.

The selector also counts the outstanding micro-ops of each macro-op tag. It raises that tag's completion bit when the last one has executed. Execution is stubbed: ALU and AGU micro-ops count as executed one cycle after issue, and multiplies count as executed on their writeback cycle.

The pool takes up to two micro-ops per cycle, sharing one macro-op tag and one ready flag. A wake input marks every entry of one tag as ready from the next cycle on.

Top module: `int_issue_select`

## Requirements
- R1: In one cycle, a lane may issue both an ALU micro-op and an AGU micro-op. For example, one ALU entry and one AGU entry both issue on lane 0.
- R2: ALU micro-ops fill the lowest permitted free ALU lane. AGU micro-ops fill the AGU lanes from lane 0 upward, so `agu_v` is always 000, 001, 011 or 111. Kind codes are 0 = ALU, 1 = AGU and 2 = multiply.
- R3: A multiply issues only on lane 0, with `mul_v` high and `alu_v[0]` high. At most one multiply issues per cycle, and a new multiply may issue in every cycle.
- R4: When entries compete for a slot, the oldest entry wins. If an older ALU entry holds lane 0, a younger multiply waits.
- R5: Exactly `MUL_LAT` cycles after a multiply issues, no non-multiply ALU micro-op issues on lane 0 or lane 1. Lane 2 stays usable in that cycle.
- R6: A ready entry issues ahead of an older entry that is not ready.
- R7: `comp_mask[t]` pulses for one cycle when the last outstanding micro-op of tag t has executed. ALU and AGU micro-ops execute one cycle after issue. A multiply executes `MUL_LAT` cycles after issue.
- R8: Reset or `flush` empties the pool, clears pending reservations and in-flight work, and clears the completion counts. After a flush, no issue and no completion occur for the discarded work.
- R9: `full` is high when fewer than two pool entries are free. An allocation offered while `full` is high is dropped.
- R10: `wake_en` with `wake_tag` makes every pooled entry of that tag ready. Those entries can issue from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard the pool, reservations and in-flight work |
| alloc_v | input | 2 | Valid flags for the two allocation slots |
| alloc_kind0 | input | 2 | Kind of allocation slot 0 (0 = ALU, 1 = AGU, 2 = multiply) |
| alloc_kind1 | input | 2 | Kind of allocation slot 1 |
| alloc_tag | input | TAGW | Macro-op tag shared by both allocation slots |
| alloc_rdy | input | 1 | Operands of the allocated micro-ops are ready |
| wake_en | input | 1 | Mark the entries of `wake_tag` as ready |
| wake_tag | input | TAGW | Tag to wake |
| full | output | 1 | Fewer than two pool entries are free |
| alu_v | output | 3 | ALU slot issue valid, one bit per lane |
| alu_tag | output | 3*TAGW | Macro-op tag issued on each ALU slot |
| mul_v | output | 1 | The lane 0 ALU slot issues a multiply |
| agu_v | output | 3 | AGU slot issue valid, one bit per lane |
| agu_tag | output | 3*TAGW | Macro-op tag issued on each AGU slot |
| comp_mask | output | 2**TAGW | Completion pulse per macro-op tag |

## Verification
The bench builds the block with its default parameters: an 8-entry pool, 3-bit tags and a multiplier latency of 3. With eight entries, four paired allocations are enough to make the pool full, so the full boundary and the dropped allocation are reached in a few cycles. A latency of 3 puts the reserved writeback cycle, and the one-cycle gap before it, inside a short directed sequence. The same latency separates the completion pulse of a multiply-bearing macro-op from that of its AGU partner.

// File: rtl/int_issue_select.sv
`timescale 1ns/1ps
module int_issue_select #(
  parameter int NENT    = 8,
  parameter int TAGW    = 3,
  parameter int MUL_LAT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [1:0]          alloc_v,
  input  logic [1:0]          alloc_kind0,
  input  logic [1:0]          alloc_kind1,
  input  logic [TAGW-1:0]     alloc_tag,
  input  logic                alloc_rdy,
  input  logic                wake_en,
  input  logic [TAGW-1:0]     wake_tag,
  output logic                full,
  output logic [2:0]          alu_v,
  output logic [3*TAGW-1:0]   alu_tag,
  output logic                mul_v,
  output logic [2:0]          agu_v,
  output logic [3*TAGW-1:0]   agu_tag,
  output logic [(1<<TAGW)-1:0] comp_mask
);
  localparam int NTAG = 1 << TAGW;
  localparam int IW   = $clog2(NENT);
  localparam int CW   = $clog2(NENT + MUL_LAT + 8);
  localparam logic [1:0] K_ALU = 2'd0, K_AGU = 2'd1, K_MUL = 2'd2;

  logic [NENT-1:0] ev, erdy, take, nv, nr;
  logic [TAGW-1:0] etag [NENT];
  logic [TAGW-1:0] ntag [NENT];
  logic [1:0]      ekind [NENT];
  logic [1:0]      nkind [NENT];
  logic [MUL_LAT-1:0] res;
  logic [TAGW-1:0] mtag [MUL_LAT];
  logic [5:0]      dv;
  logic [TAGW-1:0] dtag [6];
  logic [CW-1:0]   cnt [NTAG];
  logic [CW-1:0]   cnt_n [NTAG];
  logic            blk, acc, alloc_wake;

  assign full       = $countones(ev) > NENT - 2;
  assign blk        = res[MUL_LAT-1];
  assign acc        = !full && !flush;
  assign alloc_wake = alloc_rdy || (wake_en && wake_tag == alloc_tag);

  always_comb begin
    logic got;
    alu_v = '0; agu_v = '0; mul_v = 1'b0;
    alu_tag = '0; agu_tag = '0; take = '0;
    for (int i = 0; i < NENT; i++) begin
      got = 1'b0;
      if (ev[i] && erdy[i]) begin
        if (ekind[i] == K_MUL) begin
          if (!alu_v[0]) begin
            alu_v[0] = 1'b1; mul_v = 1'b1;
            alu_tag[TAGW-1:0] = etag[i]; take[i] = 1'b1;
          end
        end else if (ekind[i] == K_AGU) begin
          for (int l = 0; l < 3; l++)
            if (!got && !agu_v[l]) begin
              agu_v[l] = 1'b1; agu_tag[l*TAGW +: TAGW] = etag[i];
              take[i] = 1'b1; got = 1'b1;
            end
        end else begin
          for (int l = 0; l < 3; l++)
            if (!got && !alu_v[l] && (l == 2 || !blk)) begin
              alu_v[l] = 1'b1; alu_tag[l*TAGW +: TAGW] = etag[i];
              take[i] = 1'b1; got = 1'b1;
            end
        end
      end
    end
  end

  always_comb begin
    logic [IW:0] n;
    n = '0; nv = '0; nr = '0;
    for (int i = 0; i < NENT; i++) begin
      ntag[i] = '0; nkind[i] = K_ALU;
    end
    for (int i = 0; i < NENT; i++)
      if (ev[i] && !take[i]) begin
        nv[n[IW-1:0]]    = 1'b1;
        nr[n[IW-1:0]]    = erdy[i] || (wake_en && etag[i] == wake_tag);
        ntag[n[IW-1:0]]  = etag[i];
        nkind[n[IW-1:0]] = ekind[i];
        n = n + 1'b1;
      end
    for (int s = 0; s < 2; s++)
      if (acc && alloc_v[s] && n < NENT) begin
        nv[n[IW-1:0]]    = 1'b1;
        nr[n[IW-1:0]]    = alloc_wake;
        ntag[n[IW-1:0]]  = alloc_tag;
        nkind[n[IW-1:0]] = (s == 0) ? alloc_kind0 : alloc_kind1;
        n = n + 1'b1;
      end
  end

  always_comb begin
    logic [CW-1:0] v;
    for (int t = 0; t < NTAG; t++) begin
      v = cnt[t];
      for (int s = 0; s < 2; s++)
        if (acc && alloc_v[s] && alloc_tag == TAGW'(t)) v = v + 1'b1;
      for (int j = 0; j < 6; j++)
        if (dv[j] && dtag[j] == TAGW'(t)) v = v - 1'b1;
      if (res[MUL_LAT-1] && mtag[MUL_LAT-1] == TAGW'(t)) v = v - 1'b1;
      cnt_n[t]     = v;
      comp_mask[t] = !flush && cnt[t] != '0 && v == '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ev <= '0; erdy <= '0; res <= '0; dv <= '0;
      for (int t = 0; t < NTAG; t++) cnt[t] <= '0;
    end else begin
      ev   <= nv;
      erdy <= nr;
      res  <= {res[MUL_LAT-2:0], mul_v};
      dv   <= {agu_v, alu_v & {2'b11, !mul_v}};
      for (int t = 0; t < NTAG; t++) cnt[t] <= cnt_n[t];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++) begin
      etag[i]  <= ntag[i];
      ekind[i] <= nkind[i];
    end
    mtag[0] <= alu_tag[TAGW-1:0];
    for (int k = 1; k < MUL_LAT; k++) mtag[k] <= mtag[k-1];
    for (int j = 0; j < 3; j++) begin
      dtag[j]   <= alu_tag[j*TAGW +: TAGW];
      dtag[j+3] <= agu_tag[j*TAGW +: TAGW];
    end
  end

  p_agu_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!agu_v[1] || agu_v[0]) && (!agu_v[2] || agu_v[1]));
  p_mul_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mul_v |-> alu_v[0]);
  p_resv_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> (!alu_v[1] && (!alu_v[0] || mul_v)));
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alu_v == '0 && agu_v == '0 && comp_mask == '0));
endmodule

// File: tb/test_int_issue_select.sv
`timescale 1ns/1ps
module test_int_issue_select;
  localparam int TAGW = 3;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [1:0] alloc_v = '0, alloc_kind0 = '0, alloc_kind1 = '0;
  logic [TAGW-1:0] alloc_tag = '0, wake_tag = '0;
  logic alloc_rdy = 1'b0, wake_en = 1'b0;
  logic full, mul_v;
  logic [2:0] alu_v, agu_v;
  logic [3*TAGW-1:0] alu_tag, agu_tag;
  logic [7:0] comp_mask;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  int_issue_select i_int_issue_select (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_v(alloc_v),
    .alloc_kind0(alloc_kind0), .alloc_kind1(alloc_kind1), .alloc_tag(alloc_tag),
    .alloc_rdy(alloc_rdy), .wake_en(wake_en), .wake_tag(wake_tag), .full(full),
    .alu_v(alu_v), .alu_tag(alu_tag), .mul_v(mul_v), .agu_v(agu_v),
    .agu_tag(agu_tag), .comp_mask(comp_mask));

  always #4 clk = ~clk;

  // each entry: {kind0, kind1, mul_v, alu_v[2:0], agu_v[2:0]}; kinds 0=ALU 1=AGU 2=MUL
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 2'd1, 7'b0_001_001},   // R1
    {2'd0, 2'd0, 7'b0_011_000},   // R2
    {2'd1, 2'd1, 7'b0_000_011},   // R2
    {2'd2, 2'd0, 7'b1_011_000},   // R3
    {2'd0, 2'd2, 7'b0_001_000},   // R4
    {2'd2, 2'd2, 7'b1_001_000},   // R3
    {2'd1, 2'd2, 7'b1_001_001},   // R3
    {2'd2, 2'd1, 7'b1_001_001}    // R1
  };

  task automatic cyc;
    @(posedge clk); #4;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alloc(input logic [1:0] v, input logic [1:0] k0, input logic [1:0] k1,
                       input logic [TAGW-1:0] tag, input logic rdy);
    alloc_v = v; alloc_kind0 = k0; alloc_kind1 = k1; alloc_tag = tag; alloc_rdy = rdy;
    cyc;
    alloc_v = '0; alloc_rdy = 1'b0;
  endtask

  task automatic do_flush;
    flush = 1'b1; cyc; flush = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #4;
    repeat (3) cyc;
    chk("R8 reset alu", 32'(alu_v), 0);
    chk("R8 reset agu", 32'(agu_v), 0);
    chk("R8 reset comp", 32'(comp_mask), 0);
    chk("R9 reset full", 32'(full), 0);
    rst_n = 1'b1;
    cyc;

    for (int k = 0; k < 8; k++) begin
      do_flush;
      alloc(2'b11, VEC[k][10:9], VEC[k][8:7], 3'd1, 1'b1);
      chk($sformatf("R1-4 vector %0d", k), 32'({mul_v, alu_v, agu_v}), 32'(VEC[k][6:0]));
    end

    // R5: reserved writeback cycle
    do_flush;
    alloc(2'b01, 2'd2, 2'd0, 3'd1, 1'b1);
    chk("R3 mul issue", 32'(mul_v), 1);
    cyc; cyc;
    alloc(2'b11, 2'd0, 2'd0, 3'd2, 1'b1);
    chk("R5 reserved slot", 32'(alu_v), 32'b100);
    cyc;
    chk("R5 after reservation", 32'(alu_v), 32'b001);

    // R8: flush clears pending reservation and completion
    do_flush;
    alloc(2'b01, 2'd2, 2'd0, 3'd1, 1'b1);
    flush = 1'b1; cyc; flush = 1'b0;
    alloc(2'b11, 2'd0, 2'd0, 3'd2, 1'b1);
    chk("R8 reservation cleared", 32'(alu_v), 32'b011);
    chk("R8 no stale completion", 32'(comp_mask), 0);
    do_flush;
    alloc(2'b11, 2'd0, 2'd0, 3'd3, 1'b0);
    flush = 1'b1; cyc; flush = 1'b0;
    wake_en = 1'b1; wake_tag = 3'd3; cyc; wake_en = 1'b0;
    chk("R8 pool emptied", 32'(alu_v), 0);

    // R6 / R10: out of order issue and wakeup
    do_flush;
    alloc(2'b01, 2'd0, 2'd0, 3'd2, 1'b0);
    alloc(2'b01, 2'd0, 2'd0, 3'd3, 1'b1);
    chk("R6 younger ready issues", 32'(alu_v), 32'b001);
    chk("R6 younger tag", 32'(alu_tag[2:0]), 3);
    wake_en = 1'b1; wake_tag = 3'd2; cyc; wake_en = 1'b0;
    chk("R10 woken issues", 32'(alu_v), 32'b001);
    chk("R10 woken tag", 32'(alu_tag[2:0]), 2);

    // R7: completion reporting
    do_flush;
    alloc(2'b11, 2'd0, 2'd1, 3'd4, 1'b1);
    chk("R7 not yet complete", 32'(comp_mask), 0);
    cyc;
    chk("R7 alu+agu complete", 32'(comp_mask), 32'h10);
    cyc;
    chk("R7 single pulse", 32'(comp_mask), 0);
    do_flush;
    alloc(2'b11, 2'd2, 2'd1, 3'd5, 1'b1);
    cyc;
    chk("R7 waits for mul", 32'(comp_mask), 0);
    cyc;
    chk("R7 still waiting", 32'(comp_mask), 0);
    cyc;
    chk("R7 mul macro complete", 32'(comp_mask), 32'h20);

    // R9: full and dropped allocation
    do_flush;
    for (int k = 0; k < 3; k++) alloc(2'b11, 2'd0, 2'd0, 3'd6, 1'b0);
    chk("R9 six entries not full", 32'(full), 0);
    alloc(2'b11, 2'd0, 2'd0, 3'd6, 1'b0);
    chk("R9 eight entries full", 32'(full), 1);
    alloc(2'b01, 2'd1, 2'd0, 3'd7, 1'b1);
    chk("R9 allocation dropped", 32'(agu_v), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule